// File: doc/BRIEF.md
# Scope Trigger Pulse Generator

This block drives an oscilloscope trigger line in the clock domain of a device under test. It watches the device's two handshake signals. When the input-ready line drops from high to low, the device has started working. When the output-valid line is high, the device has finished. The block turns these events into a trigger waveform that a capture setup can align its traces to.

There are two trigger shapes. The first is a delayed pulse: the trigger rises a programmable number of cycles after the start event and stays high for a programmable number of cycles. The second is a busy window: the trigger is high from the start event until the device reports completion. Either shape can also be gated by the clock, so that the scope sees one edge per device cycle. The shape, delay and width are captured when the start event occurs, so a host can change them freely while an operation runs.

Top module: `scope_trig_gen`

## Requirements
- R1: A start event is `inReady` sampled high on one rising clock edge and low on the next. The edge detector clears in reset, so if `inReady` is already low when reset is released, no start occurs until it has gone high and low again.
- R2: In pulse mode (`mode[0]`=0), a start event on edge k makes the internal trigger level high from edge k+W, where W = `waitCycles`. W=0 makes it high right after edge k.
- R3: In pulse mode the level stays high for L clock cycles, where L = `lengthCycles`, and then returns low. L=0 is treated as L=1.
- R4: In window mode (`mode[0]`=1), the level goes high right after the start edge. It stays high until the first later edge on which `outValid` is sampled high, and goes low after that edge. `waitCycles` and `lengthCycles` have no effect in this mode.
- R5: When `mode[1]`=1, `trigOut` equals the internal level ANDed with `clk`. When `mode[1]`=0, `trigOut` equals the level.
- R6: Mode encoding: 0 = delayed pulse, 1 = busy window, 2 = delayed pulse gated by clock, 3 = busy window gated by clock.
- R7: `mode`, `waitCycles` and `lengthCycles` are captured on the start edge. Changing them later does not alter the operation in progress.
- R8: A start event that arrives while an operation is waiting, pulsing or in its busy window is ignored. In pulse mode the generator accepts a new start only on an edge after the one on which the level fell.
- R9: A synchronous, active-high `rst` returns the generator to idle, so the level and `trigOut` are low from the edge after `rst` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the device under test |
| rst | input | 1 | Synchronous reset, active high |
| inReady | input | 1 | Input-ready signal of the device; a falling edge starts an operation |
| outValid | input | 1 | Output-valid signal of the device; ends the busy window |
| mode | input | 2 | Trigger mode: bit 0 selects the window shape, bit 1 enables clock gating |
| waitCycles | input | CNT_W | Delay in cycles from the start edge to the rise of the pulse |
| lengthCycles | input | CNT_W | Pulse width in cycles (0 is treated as 1) |
| trigOut | output | 1 | Trigger to the oscilloscope |

## Verification
The pulse shape is tried with zero, small and larger delays and with widths of zero, one and several cycles. A zero delay shows whether the first pulse cycle lands on the right edge, and a zero width shows whether it is treated as a single cycle. The window shape is ended by `outValid` at different distances from the start, with non-zero delay and width inputs present to show that they are ignored. The output is sampled in both clock phases, which separates gated modes from ungated ones. Restarts during waiting, pulsing and windows, configuration changes part-way through an operation, a reset during an operation, and `inReady` held low out of reset each show whether the block wrongly accepts or reloads state.

// File: rtl/scope_trig_gen_pkg.sv
package scope_trig_gen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DELAY,
    ST_PULSE,
    ST_WINDOW
  } trigState_t;

  typedef struct packed {
    logic startOp;    // capture configuration and preload counter
    logic loadLen;    // reload counter with captured width
    logic countDown;  // decrement counter
    logic levelOn;    // internal trigger level
  } trigCtrl_t;

  localparam int MODE_WINDOW_BIT = 0;
  localparam int MODE_CLKGATE_BIT = 1;

endpackage

// File: rtl/scope_trig_gen_dp.sv
module scope_trig_gen_dp
  import scope_trig_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inReady,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] waitCycles,
  input  logic [CNT_W-1:0] lengthCycles,
  input  trigCtrl_t        ctrlBus,
  output logic             startSeen,
  output logic             reqWindow,
  output logic             reqNoWait,
  output logic             cntLast,
  output logic [1:0]       curMode,
  output logic             trigOut
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             readyQ;
  logic [1:0]       modeQ;
  logic [CNT_W-1:0] lenQ;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lenEff;

  always_ff @(posedge clk) begin
    if (rst) readyQ <= 1'b0;
    else     readyQ <= inReady;
  end

  assign startSeen = readyQ & ~inReady;
  assign reqWindow = mode[MODE_WINDOW_BIT];
  assign reqNoWait = (waitCycles == '0);
  assign lenEff    = (lengthCycles == '0) ? CNT_ONE : lengthCycles;

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ <= '0;
      lenQ  <= CNT_ONE;
      cnt   <= '0;
    end else if (ctrlBus.startOp) begin
      modeQ <= mode;
      lenQ  <= lenEff;
      cnt   <= reqNoWait ? lenEff : waitCycles;
    end else if (ctrlBus.loadLen) begin
      cnt <= lenQ;
    end else if (ctrlBus.countDown) begin
      cnt <= cnt - CNT_ONE;
    end
  end

  assign cntLast = (cnt == CNT_ONE);
  assign curMode = modeQ;
  assign trigOut = ctrlBus.levelOn & (modeQ[MODE_CLKGATE_BIT] ? clk : 1'b1);

endmodule

// File: rtl/scope_trig_gen_ctrl.sv
module scope_trig_gen_ctrl
  import scope_trig_gen_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      startSeen,
  input  logic      reqWindow,
  input  logic      reqNoWait,
  input  logic      cntLast,
  input  logic      outValid,
  output trigCtrl_t ctrlBus
);

  trigState_t state;
  trigState_t stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctrlBus   = '0;
    unique case (state)
      ST_IDLE: begin
        if (startSeen) begin
          ctrlBus.startOp = 1'b1;
          if (reqWindow)      stateNext = ST_WINDOW;
          else if (reqNoWait) stateNext = ST_PULSE;
          else                stateNext = ST_DELAY;
        end
      end
      ST_DELAY: begin
        if (cntLast) begin
          ctrlBus.loadLen = 1'b1;
          stateNext       = ST_PULSE;
        end else begin
          ctrlBus.countDown = 1'b1;
        end
      end
      ST_PULSE: begin
        ctrlBus.levelOn   = 1'b1;
        ctrlBus.countDown = 1'b1;
        if (cntLast) stateNext = ST_IDLE;
      end
      ST_WINDOW: begin
        ctrlBus.levelOn = 1'b1;
        if (outValid) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/scope_trig_gen.sv
module scope_trig_gen
  import scope_trig_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inReady,
  input  logic             outValid,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] waitCycles,
  input  logic [CNT_W-1:0] lengthCycles,
  output logic             trigOut
);

  trigCtrl_t  ctrlBus;
  logic       startSeen;
  logic       reqWindow;
  logic       reqNoWait;
  logic       cntLast;
  logic [1:0] curMode;
  logic       trigLevel;

  scope_trig_gen_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .startSeen (startSeen),
    .reqWindow (reqWindow),
    .reqNoWait (reqNoWait),
    .cntLast   (cntLast),
    .outValid  (outValid),
    .ctrlBus   (ctrlBus)
  );

  scope_trig_gen_dp #(.CNT_W(CNT_W)) dp_i (
    .clk          (clk),
    .rst          (rst),
    .inReady      (inReady),
    .mode         (mode),
    .waitCycles   (waitCycles),
    .lengthCycles (lengthCycles),
    .ctrlBus      (ctrlBus),
    .startSeen    (startSeen),
    .reqWindow    (reqWindow),
    .reqNoWait    (reqNoWait),
    .cntLast      (cntLast),
    .curMode      (curMode),
    .trigOut      (trigOut)
  );

  assign trigLevel = ctrlBus.levelOn;

endmodule

// File: rtl/scope_trig_gen_chk.sv
module scope_trig_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       outValid,
  input logic       trigOut,
  input logic       trigLevel,
  input logic [1:0] curMode
);

  // R9: reset forces the level low on the following cycle
  p_reset_low_r9: assert property (@(posedge clk) rst |=> !trigLevel);

  // R4: the window level holds until outValid is seen
  p_window_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (trigLevel && curMode[0] && !outValid) |=> trigLevel);

  // R4: outValid closes the window on the next cycle
  p_window_end_r4: assert property (@(posedge clk) disable iff (rst)
    (trigLevel && curMode[0] && outValid) |=> !trigLevel);

  // R5: gated modes show nothing in the low clock phase (sampled before the rising edge)
  p_gate_low_r5: assert property (@(posedge clk) disable iff (rst)
    curMode[1] |-> !trigOut);

  // R5: ungated modes pass the level straight through
  p_plain_level_r5: assert property (@(posedge clk) disable iff (rst)
    !curMode[1] |-> (trigOut == trigLevel));

endmodule

bind scope_trig_gen scope_trig_gen_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .outValid  (outValid),
  .trigOut   (trigOut),
  .trigLevel (trigLevel),
  .curMode   (curMode)
);

// File: tb/scope_trig_gen_tb_top.sv
module scope_trig_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int WATCHDOG_CYCLES = 20000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             inReady = 1'b0;
  logic             outValid = 1'b0;
  logic [1:0]       mode = 2'd0;
  logic [CNT_W-1:0] waitCycles = '0;
  logic [CNT_W-1:0] lengthCycles = '0;
  logic             trigOut;

  int    checks = 0;
  int    failures = 0;
  bit    checkOn = 1'b0;
  bit    done = 1'b0;
  string curReq = "R9";

  // behavioural schedule model
  int   edgeNum = 0;
  bit   mPrevReady = 1'b0;
  bit   mWindow = 1'b0;
  bit   mGate = 1'b0;
  bit   mWinOpen = 1'b0;
  int   mRise = 0;
  int   mFall = -1;
  bit   mLevel = 1'b0;

  scope_trig_gen #(.CNT_W(CNT_W)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .inReady      (inReady),
    .outValid     (outValid),
    .mode         (mode),
    .waitCycles   (waitCycles),
    .lengthCycles (lengthCycles),
    .trigOut      (trigOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic compare(input bit expected, input string phase);
    checks++;
    if (trigOut !== expected) begin
      failures++;
      $display("FAIL %s (%s phase, edge %0d) actual=%0b expected=%0b",
               curReq, phase, edgeNum, trigOut, expected);
    end
  endtask

  always @(posedge clk) begin
    bit idleBefore;
    bit startEv;
    int len;
    edgeNum++;
    if (rst) begin
      mPrevReady = 1'b0;
      mWindow = 1'b0;
      mGate = 1'b0;
      mWinOpen = 1'b0;
      mRise = 0;
      mFall = -1;
      mLevel = 1'b0;
    end else begin
      startEv = mPrevReady && !inReady;
      mPrevReady = inReady;
      idleBefore = mWindow ? !mWinOpen : (edgeNum > mFall);
      if (mWindow && mWinOpen && outValid) mWinOpen = 1'b0;
      if (idleBefore && startEv) begin
        mWindow = mode[0];
        mGate = mode[1];
        if (mode[0]) begin
          mWinOpen = 1'b1;
        end else begin
          len = (lengthCycles == 0) ? 1 : int'(lengthCycles);
          mRise = edgeNum + int'(waitCycles);
          mFall = mRise + len;
        end
      end
      mLevel = mWindow ? mWinOpen : ((edgeNum >= mRise) && (edgeNum < mFall));
    end
    #2;
    if (checkOn && !done) compare(mLevel, "high");
  end

  always @(negedge clk) begin
    #2;
    if (checkOn && !done) compare(mLevel && !mGate, "low");
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick(input logic [1:0] m, input int w, input int l);
    mode = m;
    waitCycles = CNT_W'(w);
    lengthCycles = CNT_W'(l);
    inReady = 1'b1;
    @(negedge clk);
    inReady = 1'b0;
    @(negedge clk);
  endtask

  task automatic closeWindow(input int n);
    idle(n);
    outValid = 1'b1;
    @(negedge clk);
    outValid = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    checkOn = 1'b1;
    curReq = "R9";
    idle(2);
    rst = 1'b0;
    idle(2);

    // R1: inReady low out of reset gives no start
    curReq = "R1";
    idle(5);

    // R2: delayed pulse, non-zero and zero delay
    curReq = "R2";
    kick(2'd0, 3, 4);
    idle(12);
    kick(2'd0, 0, 1);
    idle(5);
    kick(2'd0, 9, 2);
    idle(15);

    // R3: zero width becomes one cycle; longer width
    curReq = "R3";
    kick(2'd0, 2, 0);
    idle(6);
    kick(2'd0, 1, 7);
    idle(12);

    // R4: busy window ignores delay and width
    curReq = "R4";
    kick(2'd1, 5, 2);
    closeWindow(6);
    idle(4);
    kick(2'd1, 0, 0);
    closeWindow(0);
    idle(4);

    // R5 / R6: gated variants of both shapes
    curReq = "R5";
    kick(2'd2, 1, 3);
    idle(8);
    curReq = "R6";
    kick(2'd3, 0, 0);
    closeWindow(4);
    idle(3);

    // R7: change configuration mid-operation
    curReq = "R7";
    kick(2'd0, 4, 3);
    mode = 2'd3;
    waitCycles = '0;
    lengthCycles = 16'd9;
    idle(14);
    kick(2'd1, 0, 0);
    mode = 2'd0;
    closeWindow(3);
    idle(3);

    // R8: restart while delaying, pulsing and in a window
    curReq = "R8";
    kick(2'd0, 6, 3);
    kick(2'd0, 0, 1);
    idle(14);
    kick(2'd0, 0, 5);
    idle(1);
    kick(2'd0, 0, 1);
    idle(10);
    kick(2'd1, 0, 0);
    kick(2'd0, 0, 2);
    closeWindow(2);
    idle(6);

    // R9: reset during a pulse
    curReq = "R9";
    kick(2'd0, 2, 10);
    idle(5);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    idle(12);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule